// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models a parallel NOR flash device behind a small synchronous bus. A word-wide write strobe delivers command cycles. A multi-cycle sequencer decodes them and performs the operations they request on an on-chip byte array. These are single-word program, sector erase, buffered multi-word write and status clear. The sequencer also acknowledges lock and unlock requests and switches the source of read data. Program and erase take effect in the cycle of the final write; no device timing is modelled.

A read strobe returns one of three things, depending on the command currently selected: array data, the status byte, or a byte of a computed device-description (query) table. Status and query bytes are zero-extended to the bus width. Array words pack bytes little-endian, so the lowest byte address sits in the least significant byte. The bus width is 8, 16 or 32 bits, set by parameter. The sector size and sector count are parameters too. The array aliases into the low address bits, and the query table is indexed from the low address byte.

Top module: `pflc_top`

## Requirements
- R1: After synchronous reset, every array byte reads 0xFF, the status byte is 0, read-array mode is selected, and the sequencer waits for a command.
- R2: Command 0x10 or 0x40 arms a single program. The next write stores its data word at the addressed word and sets status bit 7. The sequencer then waits for a new command, and reads return the status byte until another mode is chosen.
- R3: Command 0x20 followed by 0xD0 erases to 0xFF the whole sector that holds the confirm address. The sector base is that address with its low log2(sector bytes) bits cleared. Status bit 7 is set, and other sectors are untouched.
- R4: After command 0x20, a second write of 0xFF aborts to read-array mode without erasing. Any other value aborts to read-array mode without erasing and raises the error pulse.
- R5: Command 0xE8 sets status bit 7. The next write carries a count N in its low 8 bits. Exactly N+1 following writes store their data words, because the counter is tested for zero before it is decremented. A 0xD0 then ends the sequence with no error.
- R6: In the buffered-write confirm cycle, a value other than 0xD0 raises the error pulse and returns to read-array mode. The words already stored are kept.
- R7: Command 0x50 clears the status byte to 0 and selects read-array mode. Commands 0xFF and 0x00 also select read-array mode.
- R8: Command 0x70 selects status reads and leaves the sequencer waiting for a command, so the next write is decoded as a new command.
- R9: Command 0x60 takes a second write. 0xD0 or 0x01 sets status bit 7 and keeps status reads. 0xFF returns to read-array mode. Any other value returns to read-array mode and raises the error pulse.
- R10: Command 0x98 selects query reads until a write of 0xFF. Writes of any other value leave query mode unchanged. The table index is the low address byte shifted right by log2(bus bytes). Indexes 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Index 0x27 returns log2 of the array size in bytes. Index 0x3D and above returns 0.
- R11: An unrecognised command in the waiting state selects read-array mode and raises the error output for exactly the one cycle after that write.
- R12: Read data is registered. It appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe; one command or data cycle per asserted clock |
| rd_en | input | 1 | Read strobe; rdata is updated at this edge |
| addr | input | ADDR_W | Byte address; word accesses ignore the low log2(bus bytes) bits |
| wdata | input | DATA_W | Write data; commands are taken from bits 7:0 |
| rdata | output | DATA_W | Registered read data |
| err | output | 1 | One-cycle pulse after a rejected command sequence |

## Verification
The checker assumes that a read strobe and a write strobe never occur in the same cycle. It also assumes that each write carries its command in the low byte, and that addresses are word-aligned. The bench drives every strobe for exactly one clock from the falling edge and never overlaps reads with writes. It uses only aligned addresses, except for query reads, whose index comes from the full low address byte. Counts for buffered writes stay small, so the sequence length is known in advance.

// File: rtl/pflc_pkg.sv
package pflc_pkg;

   typedef enum logic [1:0] {
      WC_IDLE        = 2'd0,
      WC_ARG         = 2'd1,
      WC_BUF_DATA    = 2'd2,
      WC_BUF_CONFIRM = 2'd3
   } wcycle_e;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_STATUS = 2'd1,
      SRC_QUERY  = 2'd2
   } rsrc_e;

   localparam logic [7:0] OP_NULL     = 8'h00;
   localparam logic [7:0] OP_LOCK_ALT = 8'h01;
   localparam logic [7:0] OP_PROG_A   = 8'h10;
   localparam logic [7:0] OP_ERASE    = 8'h20;
   localparam logic [7:0] OP_PROG_B   = 8'h40;
   localparam logic [7:0] OP_CLR_STAT = 8'h50;
   localparam logic [7:0] OP_LOCK     = 8'h60;
   localparam logic [7:0] OP_STAT     = 8'h70;
   localparam logic [7:0] OP_QUERY    = 8'h98;
   localparam logic [7:0] OP_CONFIRM  = 8'hD0;
   localparam logic [7:0] OP_BUF      = 8'hE8;
   localparam logic [7:0] OP_READ_ARR = 8'hFF;

   localparam logic [7:0] STAT_READY  = 8'h80;
   localparam int         QRY_LEN     = 'h3D;

   // Device-description byte for one table index; geometry bytes are derived.
   function automatic logic [7:0] qry_byte(input logic [7:0] idx,
                                           input int lg_total,
                                           input int nsec,
                                           input int sbytes);
      logic [7:0] v;
      v = 8'h00;
      case (idx)
         8'h10: v = 8'h51;
         8'h11: v = 8'h52;
         8'h12: v = 8'h59;
         8'h13: v = 8'h01;
         8'h15: v = 8'h31;
         8'h1B: v = 8'h45;
         8'h1C: v = 8'h55;
         8'h1F, 8'h20: v = 8'h07;
         8'h21: v = 8'h0A;
         8'h23, 8'h24, 8'h25: v = 8'h04;
         8'h27: v = 8'(lg_total);
         8'h28: v = 8'h02;
         8'h2A: v = 8'h0B;
         8'h2C: v = 8'h01;
         8'h2D: v = 8'((nsec - 1) & 255);
         8'h2E: v = 8'((nsec - 1) >> 8);
         8'h2F: v = 8'(sbytes >> 8);
         8'h30: v = 8'(sbytes >> 16);
         8'h31: v = 8'h50;
         8'h32: v = 8'h52;
         8'h33: v = 8'h49;
         8'h34, 8'h35: v = 8'h31;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pflc_array.sv
module pflc_array #(
   parameter int DATA_W       = 16,
   parameter int SECTOR_BYTES = 16,
   parameter int NUM_SECTORS  = 4
) (
   input  logic                                            clk,
   input  logic                                            rst,
   input  logic                                            wr,
   input  logic [$clog2((SECTOR_BYTES*NUM_SECTORS)/(DATA_W/8))-1:0] wr_word,
   input  logic [DATA_W-1:0]                               wr_data,
   input  logic                                            er,
   input  logic [$clog2(NUM_SECTORS)-1:0]                  er_sector,
   input  logic [$clog2((SECTOR_BYTES*NUM_SECTORS)/(DATA_W/8))-1:0] rd_word,
   output logic [DATA_W-1:0]                               rd_data
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int TOTAL      = SECTOR_BYTES * NUM_SECTORS;
   localparam int NWORDS     = TOTAL / WORD_BYTES;
   localparam int WIDX_W     = $clog2(NWORDS);
   localparam int SEC_W      = $clog2(NUM_SECTORS);
   localparam int BIDX_W     = $clog2(TOTAL);

   logic [TOTAL*8-1:0] mem_flat;

   // One cell per byte: program by word/lane match, erase by sector match.
   for (genvar b = 0; b < TOTAL; b++) begin : g_cell
      localparam int WORD_OF = b / WORD_BYTES;
      localparam int LANE_OF = b % WORD_BYTES;
      localparam int SEC_OF  = b / SECTOR_BYTES;
      logic [7:0] cell_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            cell_q <= 8'hFF;
         end else if (er && (er_sector == SEC_W'(SEC_OF))) begin
            cell_q <= 8'hFF;
         end else if (wr && (wr_word == WIDX_W'(WORD_OF))) begin
            cell_q <= wr_data[8*LANE_OF +: 8];
         end
      end
      assign mem_flat[8*b +: 8] = cell_q;
   end

   // Little-endian packing: lowest byte address in lane 0.
   for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
      logic [BIDX_W-1:0] bidx;
      assign bidx = BIDX_W'(rd_word) * BIDX_W'(WORD_BYTES) + BIDX_W'(l);
      assign rd_data[8*l +: 8] = mem_flat[8*bidx +: 8];
   end

endmodule

// File: rtl/pflc_query.sv
module pflc_query #(
   parameter int DATA_W       = 16,
   parameter int SECTOR_BYTES = 16,
   parameter int NUM_SECTORS  = 4
) (
   input  logic [7:0] addr_lo,
   output logic [7:0] qbyte
);
   import pflc_pkg::*;

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int LG_TOTAL   = $clog2(SECTOR_BYTES * NUM_SECTORS);

   logic [7:0] idx;

   // Index scaling depends on bus width.
   if (WORD_BYTES == 1) begin : g_x8
      assign idx = addr_lo;
   end else if (WORD_BYTES == 2) begin : g_x16
      assign idx = {1'b0, addr_lo[7:1]};
   end else begin : g_x32
      assign idx = {2'b00, addr_lo[7:2]};
   end

   always_comb begin
      if (int'(idx) >= QRY_LEN) qbyte = 8'h00;
      else qbyte = qry_byte(idx, LG_TOTAL, NUM_SECTORS, SECTOR_BYTES);
   end

endmodule

// File: rtl/pflc_seq.sv
module pflc_seq #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr_en,
   input  logic [DATA_W-1:0]       wdata,
   output logic [7:0]              cmd_q,
   output pflc_pkg::wcycle_e       wc_q,
   output logic [7:0]              status_q,
   output logic                    err_q,
   output logic                    prog_we,
   output logic                    erase_en
);
   import pflc_pkg::*;

   logic [7:0]       op;
   logic [7:0]       cmd_d;
   wcycle_e          wc_d;
   logic [7:0]       stat_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             err_d;

   assign op = wdata[7:0];

   always_comb begin
      cmd_d    = cmd_q;
      wc_d     = wc_q;
      stat_d   = status_q;
      cnt_d    = cnt_q;
      err_d    = 1'b0;
      prog_we  = 1'b0;
      erase_en = 1'b0;
      if (wr_en) begin
         case (wc_q)
            WC_IDLE: begin
               case (op)
                  OP_NULL, OP_READ_ARR: cmd_d = OP_NULL;
                  OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_QUERY: begin
                     cmd_d = op;
                     wc_d  = WC_ARG;
                  end
                  OP_BUF: begin
                     cmd_d  = op;
                     wc_d   = WC_ARG;
                     stat_d = status_q | STAT_READY;
                  end
                  OP_CLR_STAT: begin
                     stat_d = 8'h00;
                     cmd_d  = OP_NULL;
                  end
                  OP_STAT: cmd_d = OP_STAT;
                  default: begin
                     err_d = 1'b1;
                     cmd_d = OP_NULL;
                  end
               endcase
            end
            WC_ARG: begin
               case (cmd_q)
                  OP_PROG_A, OP_PROG_B: begin
                     prog_we = 1'b1;
                     stat_d  = status_q | STAT_READY;
                     wc_d    = WC_IDLE;
                  end
                  OP_ERASE: begin
                     wc_d = WC_IDLE;
                     if (op == OP_CONFIRM) begin
                        erase_en = 1'b1;
                        stat_d   = status_q | STAT_READY;
                     end else begin
                        cmd_d = OP_NULL;
                        err_d = (op != OP_READ_ARR);
                     end
                  end
                  OP_BUF: begin
                     cnt_d = wdata[CNT_W-1:0];
                     wc_d  = WC_BUF_DATA;
                  end
                  OP_LOCK: begin
                     wc_d = WC_IDLE;
                     if (op == OP_CONFIRM || op == OP_LOCK_ALT) begin
                        stat_d = status_q | STAT_READY;
                     end else begin
                        cmd_d = OP_NULL;
                        err_d = (op != OP_READ_ARR);
                     end
                  end
                  OP_QUERY: begin
                     if (op == OP_READ_ARR) begin
                        cmd_d = OP_NULL;
                        wc_d  = WC_IDLE;
                     end
                  end
                  default: begin
                     err_d = 1'b1;
                     cmd_d = OP_NULL;
                     wc_d  = WC_IDLE;
                  end
               endcase
            end
            WC_BUF_DATA: begin
               prog_we = 1'b1;
               stat_d  = status_q | STAT_READY;
               if (cnt_q == '0) wc_d = WC_BUF_CONFIRM;
               cnt_d = cnt_q - 1'b1;
            end
            default: begin
               wc_d = WC_IDLE;
               if (op == OP_CONFIRM) begin
                  stat_d = status_q | STAT_READY;
               end else begin
                  err_d = 1'b1;
                  cmd_d = OP_NULL;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q    <= OP_NULL;
         wc_q     <= WC_IDLE;
         status_q <= 8'h00;
         cnt_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         cmd_q    <= cmd_d;
         wc_q     <= wc_d;
         status_q <= stat_d;
         cnt_q    <= cnt_d;
         err_q    <= err_d;
      end
   end

endmodule

// File: rtl/pflc_top.sv
module pflc_top #(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 8,
   parameter int SECTOR_BYTES = 16,
   parameter int NUM_SECTORS  = 4,
   parameter int CNT_W        = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);
   import pflc_pkg::*;

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int TOTAL      = SECTOR_BYTES * NUM_SECTORS;
   localparam int WOFF       = $clog2(WORD_BYTES);
   localparam int WIDX_W     = $clog2(TOTAL / WORD_BYTES);
   localparam int SOFF       = $clog2(SECTOR_BYTES);
   localparam int SEC_W      = $clog2(NUM_SECTORS);

   if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32))
      $error("pflc_top: DATA_W must be 8, 16 or 32");
   if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES < WORD_BYTES)
      $error("pflc_top: SECTOR_BYTES must be a power of two of at least one word");
   if ((NUM_SECTORS & (NUM_SECTORS - 1)) != 0 || NUM_SECTORS < 2)
      $error("pflc_top: NUM_SECTORS must be a power of two of at least 2");
   if (ADDR_W < 8 || ADDR_W < $clog2(TOTAL))
      $error("pflc_top: ADDR_W must cover the array and the query byte");
   if (CNT_W > DATA_W)
      $error("pflc_top: CNT_W must not exceed DATA_W");

   logic [7:0]        cmd_w;
   wcycle_e           wc_w;
   logic [7:0]        stat_w;
   logic              prog_we, erase_en;
   logic [DATA_W-1:0] arr_rd;
   logic [7:0]        qbyte;
   rsrc_e             src;
   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] rdata_q;

   pflc_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wdata    (wdata),
      .cmd_q    (cmd_w),
      .wc_q     (wc_w),
      .status_q (stat_w),
      .err_q    (err),
      .prog_we  (prog_we),
      .erase_en (erase_en)
   );

   pflc_array #(.DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES),
                .NUM_SECTORS(NUM_SECTORS)) u_array (
      .clk       (clk),
      .rst       (rst),
      .wr        (prog_we),
      .wr_word   (addr[WOFF +: WIDX_W]),
      .wr_data   (wdata),
      .er        (erase_en),
      .er_sector (addr[SOFF +: SEC_W]),
      .rd_word   (addr[WOFF +: WIDX_W]),
      .rd_data   (arr_rd)
   );

   pflc_query #(.DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES),
                .NUM_SECTORS(NUM_SECTORS)) u_query (
      .addr_lo (addr[7:0]),
      .qbyte   (qbyte)
   );

   always_comb begin
      case (cmd_w)
         OP_NULL:  src = SRC_ARRAY;
         OP_QUERY: src = SRC_QUERY;
         default:  src = SRC_STATUS;
      endcase
   end

   always_comb begin
      case (src)
         SRC_ARRAY: rd_next = arr_rd;
         SRC_QUERY: rd_next = DATA_W'(qbyte);
         default:   rd_next = DATA_W'(stat_w);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_next;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/pflc_checker.sv
module pflc_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              err,
   input pflc_pkg::wcycle_e wc,
   input logic [7:0]        cmd,
   input logic [7:0]        status
);
   import pflc_pkg::*;

   // R11: an error pulse only ever follows a write cycle
   a_r11_err_after_write: assert property (@(posedge clk) disable iff (rst)
      err |-> $past(wr_en));

   // R7: status clear from the waiting state empties the status byte
   a_r7_clear_status: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wc == WC_IDLE && wdata[7:0] == OP_CLR_STAT) |=> (status == 8'h00));

   // R8: status command does not advance the write cycle
   a_r8_stat_no_advance: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wc == WC_IDLE && wdata[7:0] == OP_STAT) |=> (wc == WC_IDLE && cmd == OP_STAT));

   // R2: program data cycle sets ready and returns to waiting
   a_r2_prog_done: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wc == WC_ARG && (cmd == OP_PROG_A || cmd == OP_PROG_B))
      |=> (status[7] && wc == WC_IDLE));

   // R6: bad buffered-write confirm pulses error and leaves for read-array
   a_r6_bad_confirm: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wc == WC_BUF_CONFIRM && wdata[7:0] != OP_CONFIRM)
      |=> (err && wc == WC_IDLE && cmd == OP_NULL));

   // R12: a status-mode read returns the status byte in the following cycle
   a_r12_status_read: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !wr_en && cmd == OP_STAT) |=> (rdata == DATA_W'($past(status))));

   // R12: read data holds when no read strobe is given
   a_r12_hold: assert property (@(posedge clk) disable iff (rst)
      (!rd_en && !$past(rst)) |=> $stable(rdata));

endmodule

bind pflc_top pflc_checker #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .wr_en  (wr_en),
   .rd_en  (rd_en),
   .wdata  (wdata),
   .rdata  (rdata),
   .err    (err),
   .wc     (wc_w),
   .cmd    (cmd_w),
   .status (stat_w)
);

// File: tb/tb_pflc_top.sv
module tb_pflc_top;

   localparam int DW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          pend = 1'b0;

   always #2.5 clk = ~clk;

   pflc_top #(.DATA_W(DW), .ADDR_W(AW), .SECTOR_BYTES(16), .NUM_SECTORS(4),
              .CNT_W(8)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per read, compares after the capture edge.
   always @(posedge clk) pend <= rd_en;
   always @(negedge clk) begin
      if (pend) begin
         if (exp_q.size() == 0) begin
            check("scoreboard_underflow", 16'h0, 16'h1);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      check("R1 err after reset", {15'b0, err}, 16'h0);
      rd(8'h00, 16'hFFFF, "R1 array erased after reset");
      rd(8'h3E, 16'hFFFF, "R1 last word erased after reset");
      wr(8'h00, 16'h0070);
      rd(8'h00, 16'h0000, "R1 status zero after reset");
      // R8: the next write is taken as a command
      wr(8'h00, 16'h00FF);
      rd(8'h00, 16'hFFFF, "R8 write after 0x70 decoded as command");

      // R2: single program with both opcodes
      wr(8'h04, 16'h0040);
      wr(8'h04, 16'hBEEF);
      check("R2 no error on program", {15'b0, err}, 16'h0);
      rd(8'h04, 16'h0080, "R2 status read after program");
      wr(8'h00, 16'h00FF);
      rd(8'h04, 16'hBEEF, "R2 programmed word 0x40");
      wr(8'h12, 16'h0010);
      wr(8'h12, 16'h1234);
      wr(8'h00, 16'h00FF);
      rd(8'h12, 16'h1234, "R2 programmed word 0x10");

      // R12: read data holds between strobes
      repeat (3) @(negedge clk);
      check("R12 rdata holds", rdata, 16'h1234);

      // R7: clear status and read-array via 0x00
      wr(8'h00, 16'h0050);
      rd(8'h04, 16'hBEEF, "R7 read-array after 0x50");
      wr(8'h00, 16'h0070);
      rd(8'h00, 16'h0000, "R7 status cleared by 0x50");
      wr(8'h00, 16'h0000);
      rd(8'h04, 16'hBEEF, "R7 read-array after 0x00");

      // R5: buffered write of N+1 words
      wr(8'h20, 16'h00E8);
      rd(8'h20, 16'h0080, "R5 status during buffered write");
      wr(8'h20, 16'h0002);
      wr(8'h20, 16'h1111);
      wr(8'h22, 16'h2222);
      wr(8'h24, 16'h3333);
      wr(8'h20, 16'h00D0);
      check("R5 no error on confirm", {15'b0, err}, 16'h0);
      wr(8'h00, 16'h00FF);
      rd(8'h20, 16'h1111, "R5 word 0");
      rd(8'h22, 16'h2222, "R5 word 1");
      rd(8'h24, 16'h3333, "R5 word 2");
      rd(8'h26, 16'hFFFF, "R5 no extra word");

      // R3: sector erase of 0x20..0x2F
      wr(8'h24, 16'h0020);
      wr(8'h24, 16'h00D0);
      check("R3 no error on erase", {15'b0, err}, 16'h0);
      rd(8'h24, 16'h0080, "R3 status after erase");
      wr(8'h00, 16'h00FF);
      rd(8'h20, 16'hFFFF, "R3 sector base erased");
      rd(8'h24, 16'hFFFF, "R3 sector word erased");
      rd(8'h12, 16'h1234, "R3 other sector kept");
      rd(8'h04, 16'hBEEF, "R3 first sector kept");

      // R4: erase aborts
      wr(8'h04, 16'h0020);
      wr(8'h04, 16'h00FF);
      check("R4 abort no error", {15'b0, err}, 16'h0);
      rd(8'h04, 16'hBEEF, "R4 abort leaves data");
      wr(8'h04, 16'h0020);
      wr(8'h04, 16'h0055);
      check("R4 bad confirm errors", {15'b0, err}, 16'h1);
      rd(8'h04, 16'hBEEF, "R4 bad confirm no erase, array mode");

      // R6: bad buffered-write confirm
      wr(8'h30, 16'h00E8);
      wr(8'h30, 16'h0000);
      wr(8'h30, 16'h5A5A);
      wr(8'h30, 16'h0077);
      check("R6 bad confirm errors", {15'b0, err}, 16'h1);
      rd(8'h30, 16'h5A5A, "R6 array mode, word kept");

      // R9: lock/unlock second cycle
      wr(8'h00, 16'h0050);
      wr(8'h00, 16'h0060);
      wr(8'h00, 16'h00D0);
      rd(8'h00, 16'h0080, "R9 lock 0xD0 sets ready");
      wr(8'h00, 16'h0050);
      wr(8'h00, 16'h0060);
      wr(8'h00, 16'h0001);
      rd(8'h00, 16'h0080, "R9 lock 0x01 sets ready");
      wr(8'h00, 16'h0050);
      wr(8'h00, 16'h0060);
      wr(8'h00, 16'h0033);
      check("R9 bad lock value errors", {15'b0, err}, 16'h1);
      rd(8'h04, 16'hBEEF, "R9 bad lock value read-array");
      wr(8'h00, 16'h0070);
      rd(8'h00, 16'h0000, "R9 bad lock value leaves status clear");
      wr(8'h00, 16'h00FF);

      // R10: query mode
      wr(8'h00, 16'h0098);
      rd(8'h20, 16'h0051, "R10 query index 0x10");
      rd(8'h22, 16'h0052, "R10 query index 0x11");
      rd(8'h24, 16'h0059, "R10 query index 0x12");
      rd(8'h4E, 16'h0006, "R10 query size log2");
      rd(8'h7A, 16'h0000, "R10 query past end");
      wr(8'h00, 16'h0012);
      rd(8'h20, 16'h0051, "R10 query held on non-0xFF write");
      wr(8'h00, 16'h00FF);
      rd(8'h04, 16'hBEEF, "R10 query left by 0xFF");

      // R11: unknown command
      wr(8'h00, 16'h0033);
      check("R11 unknown command pulses error", {15'b0, err}, 16'h1);
      @(negedge clk);
      check("R11 error lasts one cycle", {15'b0, err}, 16'h0);
      rd(8'h04, 16'hBEEF, "R11 read-array after unknown command");

      repeat (3) @(negedge clk);
      check("scoreboard empty", 16'(exp_q.size()), 16'h0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule